// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block is the digital front end of a 16-bit voltage-output converter. A host writes to it over a three-wire, write-only serial link: an active-low frame select, a serial clock and a data line. Each frame carries 24 bits, sent most significant bit first. The block assembles the bits into a 16-bit conversion code and a 2-bit output mode. It transfers both into its holding registers at one instant, when the 24th bit arrives.

All three link wires are resynchronised into a system clock that runs at least four times faster than the serial clock. Edges are then found in that domain. If the host releases the frame select early, the partial frame is discarded and the held values stay as they were. The block presents the held code and mode, plus a single-cycle strobe for each accepted frame. A parameter chooses whether the code comes out of reset at zero or at midscale.

Top module: `serdac_frame_rx`

## Requirements
- R1: During and after reset, before any accepted frame: `update_o` is 0 and `mode_o` is 2'b00. `code_o` is 16'h0000 when `RESET_MID` is 0, and 16'h8000 when `RESET_MID` is 1.
- R2: A frame begins when the frame select falls. Data is taken on each falling serial clock edge, and the first bit taken becomes bit 23 of the frame.
- R3: When the 24th falling edge of a frame is taken, frame bits 15..0 are loaded into `code_o` and bits 17..16 into `mode_o` in the same system cycle. At no other time do these outputs change.
- R4: Frame bits 23..18 have no effect on any output.
- R5: If the frame select rises before the 24th falling edge, the partial frame is discarded: `code_o` and `mode_o` keep their values and no strobe is given. The next frame is assembled from empty.
- R6: `mode_o` reports the mode field as received: 00 normal, 01 ground through 1 kΩ, 10 ground through 100 kΩ, 11 high impedance. A power-down mode does not clear or alter `code_o`.
- R7: Serial clock edges after the 24th, while the frame select stays low, are ignored. A new frame is only accepted after the frame select goes high and then low again.
- R8: Serial clock edges while the frame select is high are ignored.
- R9: `update_o` is high for exactly one system cycle for each accepted frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous to `clk` |
| fsel_n_i | input | 1 | Active-low frame select, asynchronous |
| sdata_i | input | 1 | Serial data, sampled on falling `sclk_i` |
| code_o | output | 16 | Held conversion code |
| mode_o | output | 2 | Held output mode |
| update_o | output | 1 | One-cycle strobe when a frame is accepted |

## Verification
Complete frames carry asymmetric codes, such as 16'h1234 and 16'h8001, so that a reversed or shifted bit order shows up at once. The pad bits are set to all ones, alternating patterns and all zeros to show they are never decoded. Every mode value is written, and so is a power-down mode with a nonzero code, to show that the code survives. Frames cut short after 0, 10 and 23 bits separate an early commit from a correct discard. Extra clocks with the select held low, and clocks with the select high, show that only a fresh select fall opens a frame.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;
  typedef enum logic [1:0] {
    MODE_RUN      = 2'b00,
    MODE_GND_LOW  = 2'b01,
    MODE_GND_HIGH = 2'b10,
    MODE_FLOAT    = 2'b11
  } pd_mode_t;
endpackage

// File: rtl/dacrx_sync.sv
module dacrx_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] IDLE  = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{IDLE[b]}};
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/dacrx_frame.sv
module dacrx_frame #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               fsn_s,
  input  logic               din_s,
  output logic               commit_o,
  output logic [FRAME_W-1:0] word_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               sclk_d, fsn_d, active;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg, nxt;
  logic               sclk_fall, fs_fall, fs_rise, take, last;

  always_comb begin
    sclk_fall = sclk_d & ~sclk_s;
    fs_fall   = fsn_d & ~fsn_s;
    fs_rise   = ~fsn_d & fsn_s;
    take      = sclk_fall & active & (cnt < FULL);
    last      = take & (cnt == LAST);
    nxt       = {shreg[FRAME_W-2:0], din_s};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b1;
      fsn_d    <= 1'b1;
      active   <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      commit_o <= 1'b0;
      word_o   <= '0;
    end else begin
      sclk_d   <= sclk_s;
      fsn_d    <= fsn_s;
      commit_o <= 1'b0;
      if (fs_rise) begin
        active <= 1'b0;
        cnt    <= '0;
        shreg  <= '0;
      end else if (fs_fall) begin
        active <= 1'b1;
        cnt    <= '0;
        shreg  <= '0;
      end else if (take) begin
        shreg <= nxt;
        cnt   <= cnt + 1'b1;
        if (last) begin
          commit_o <= 1'b1;
          word_o   <= nxt;
        end
      end
    end
  end

  // R7: the bit counter never runs past one frame
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
  // R5: an early select release empties the frame with no commit
  a_r5_cancel_clears: assert property (@(posedge clk) disable iff (rst)
    fs_rise |=> (cnt == '0) && !commit_o);
  // R8: with the select held high nothing is shifted
  a_r8_idle_no_shift: assert property (@(posedge clk) disable iff (rst)
    (fsn_s && fsn_d) |=> $stable(cnt) && $stable(shreg));
endmodule

// File: rtl/dacrx_hold.sv
module dacrx_hold
  import dacrx_pkg::*;
#(
  parameter int CODE_W    = 16,
  parameter int MODE_W    = 2,
  parameter bit RESET_MID = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [CODE_W-1:0] code_o,
  output pd_mode_t          mode_o,
  output logic              update_o
);
  localparam logic [CODE_W-1:0] RST_CODE =
    RESET_MID ? (CODE_W'(1) << (CODE_W - 1)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o   <= RST_CODE;
      mode_o   <= MODE_RUN;
      update_o <= 1'b0;
    end else begin
      update_o <= commit_i;
      if (commit_i) begin
        code_o <= code_i;
        mode_o <= pd_mode_t'(mode_i);
      end
    end
  end

  // R3: held values move only on a commit
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> $stable(code_o) && $stable(mode_o));
  // R9: each commit raises the strobe
  a_r9_commit_strobe: assert property (@(posedge clk) disable iff (rst)
    commit_i |=> update_o);
endmodule

// File: rtl/serdac_frame_rx.sv
module serdac_frame_rx
  import dacrx_pkg::*;
#(
  parameter int CODE_W    = 16,
  parameter int MODE_W    = 2,
  parameter int PAD_W     = 6,
  parameter int SYNC_STG  = 2,
  parameter bit RESET_MID = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              fsel_n_i,
  input  logic              sdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              update_o
);
  localparam int FRAME_W = PAD_W + MODE_W + CODE_W;

  logic [2:0]         raw, synced;
  logic               commit;
  logic [FRAME_W-1:0] word;
  pd_mode_t           mode_q;

  assign raw = {sclk_i, fsel_n_i, sdata_i};

  dacrx_sync #(.W(3), .STAGES(SYNC_STG), .IDLE(3'b111)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  dacrx_frame #(.FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst(rst),
    .sclk_s(synced[2]), .fsn_s(synced[1]), .din_s(synced[0]),
    .commit_o(commit), .word_o(word)
  );

  dacrx_hold #(.CODE_W(CODE_W), .MODE_W(MODE_W), .RESET_MID(RESET_MID)) u_hold (
    .clk(clk), .rst(rst), .commit_i(commit),
    .code_i(word[CODE_W-1:0]),
    .mode_i(word[CODE_W +: MODE_W]),
    .code_o(code_o), .mode_o(mode_q), .update_o(update_o)
  );

  assign mode_o = MODE_W'(mode_q);

  // R9: strobe lasts a single cycle
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
    update_o |=> !update_o);
  // R3: a code change is always accompanied by the strobe
  a_r3_code_with_strobe: assert property (@(posedge clk) disable iff (rst)
    (code_o != $past(code_o)) |-> update_o);
endmodule

// File: tb/tb_serdac_frame_rx.sv
module tb_serdac_frame_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b1;
  logic        fsn = 1'b1;
  logic        sdata = 1'b0;
  logic [15:0] code, code_m;
  logic [1:0]  mode, mode_m;
  logic        upd, upd_m;

  int checks = 0;
  int fails  = 0;
  int upd_cnt = 0;
  int cyc = 0;
  logic upd_prev = 1'b0;

  always #2 clk = ~clk;

  serdac_frame_rx dut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .fsel_n_i(fsn), .sdata_i(sdata),
    .code_o(code), .mode_o(mode), .update_o(upd)
  );

  serdac_frame_rx #(.RESET_MID(1'b1)) dut_mid (
    .clk(clk), .rst(rst), .sclk_i(sclk), .fsel_n_i(fsn), .sdata_i(sdata),
    .code_o(code_m), .mode_o(mode_m), .update_o(upd_m)
  );

  typedef struct packed {
    logic [23:0] w;
    logic [4:0]  nb;
    logic [15:0] code;
    logic [1:0]  mode;
    logic        upd;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{ {6'b000000, 2'b00, 16'h1234}, 5'd24, 16'h1234, 2'b00, 1'b1 },
    '{ {6'b111111, 2'b01, 16'hABCD}, 5'd24, 16'hABCD, 2'b01, 1'b1 },
    '{ {6'b101010, 2'b10, 16'hFFFF}, 5'd10, 16'hABCD, 2'b01, 1'b0 },
    '{ {6'b000000, 2'b11, 16'h0000}, 5'd23, 16'hABCD, 2'b01, 1'b0 },
    '{ {6'b010101, 2'b10, 16'h8001}, 5'd24, 16'h8001, 2'b10, 1'b1 },
    '{ {6'b000000, 2'b11, 16'h5A5A}, 5'd24, 16'h5A5A, 2'b11, 1'b1 },
    '{ {6'b110011, 2'b00, 16'hFFFF}, 5'd0,  16'h5A5A, 2'b11, 1'b0 },
    '{ {6'b000000, 2'b00, 16'h0000}, 5'd24, 16'h0000, 2'b00, 1'b1 }
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // strobe monitor, sampled away from the active edge (R9)
  always @(negedge clk) begin
    if (!rst) begin
      if (upd) upd_cnt++;
      if (upd && upd_prev) begin
        checks++;
        fails++;
        $display("FAIL R9: actual strobe width 2+ expected 1");
      end
      upd_prev = upd;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic fs_low();
    @(negedge clk); fsn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic fs_high();
    repeat (4) @(negedge clk);
    fsn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic clk_bits(input logic [23:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sdata = w[23-i];
      sclk  = 1'b1;
      repeat (4) @(negedge clk);
      sclk  = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    int base;
    repeat (5) @(negedge clk);
    // R1: reset values for both variants
    check("R1 code zero variant", 32'(code), 32'h0000);
    check("R1 code mid variant", 32'(code_m), 32'h8000);
    check("R1 mode", 32'(mode), 32'h0);
    check("R1 strobe", 32'(upd), 32'h0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 code after release", 32'(code_m), 32'h8000);

    // table: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      base = upd_cnt;
      fs_low();
      clk_bits(VEC[v].w, int'(VEC[v].nb));
      fs_high();
      check($sformatf("R3/R2 code vec %0d", v), 32'(code), 32'(VEC[v].code));
      check($sformatf("R6/R4 mode vec %0d", v), 32'(mode), 32'(VEC[v].mode));
      check($sformatf("R5/R9 strobes vec %0d", v), 32'(upd_cnt - base), 32'(VEC[v].upd));
    end

    // R8: clocks with select high are ignored
    base = upd_cnt;
    clk_bits({6'b0, 2'b01, 16'hDEAD}, 30);
    repeat (8) @(negedge clk);
    check("R8 code unchanged", 32'(code), 32'h0000);
    check("R8 no strobe", 32'(upd_cnt - base), 32'd0);

    // R7: extra clocks after 24th and no re-arm without select rise
    base = upd_cnt;
    fs_low();
    clk_bits({6'b0, 2'b10, 16'h0F0F}, 24);
    repeat (8) @(negedge clk);
    check("R7 first frame code", 32'(code), 32'h0F0F);
    check("R6 power-down keeps code", 32'(mode), 32'h2);
    clk_bits({6'b0, 2'b00, 16'hC3C3}, 30);
    repeat (8) @(negedge clk);
    check("R7 extra clocks ignored code", 32'(code), 32'h0F0F);
    check("R7 extra clocks ignored mode", 32'(mode), 32'h2);
    check("R7 single strobe", 32'(upd_cnt - base), 32'd1);
    fs_high();
    fs_low();
    clk_bits({6'b111000, 2'b01, 16'h7FFE}, 24);
    fs_high();
    check("R7 rearmed frame code", 32'(code), 32'h7FFE);
    check("R7 rearmed frame mode", 32'(mode), 32'h1);
    check("R9 strobe count", 32'(upd_cnt - base), 32'd2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule